// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block sits on one 36-bit bidirectional data port. The port is split into four 9-bit lanes. In each lane the eight low bits carry payload and the top bit carries parity. Words arriving on the port are checked without being changed. An active-low error flag goes low while any lane of the incoming word breaks the selected parity sense. The flag only advises: the block never drops or alters data because of it.

On the read side, the block takes the raw word that the surrounding port logic wants to drive out. It registers that word for output, and can first replace every lane's top bit with freshly computed parity. One odd/even input sets the parity sense for both checking and generation.

The parity trees that check incoming data are shared with generation for mailbox reads. While a mailbox read with generation is set up, those trees look at the outgoing word, so the error flag is held inactive. Ordinary (queue-path) reads with generation use their own, dedicated trees.

Top module: `byte_lane_parity`

## Requirements
- R1: The 36-bit word is four lanes: bits 8:0, 17:9, 26:18 and 35:27. Bit 8, 17, 26 or 35 is the parity bit of its lane, and the other eight bits of each lane are its payload.
- R2: With `odd_sel` = 1, a lane passes when its nine bits hold an odd number of ones. With `odd_sel` = 0, a lane passes when they hold an even number of ones. `perr_n` is 0 when at least one lane of `port_in` fails, and 1 when all four lanes pass.
- R3: `perr_n` is combinational. It follows `port_in`, `odd_sel` and the port controls in the same cycle, without waiting for a clock edge. Reset does not affect it.
- R4: A mailbox read with generation is set up when `cs_n`=0, `en`=1, `wr_rd`=0 (0 means read), `mbx_sel`=1 and `gen_en`=1. For such a read, `rd_out` after the next rising clock edge has each lane's payload equal to `rd_data`. Each lane's top bit is replaced so that the lane has the parity sense that `odd_sel` selects.
- R5: A queue read (`cs_n`=0, `en`=1, `wr_rd`=0, `mbx_sel`=0) with `gen_en`=1 regenerates the parity bits in the same way as R4.
- R6: A read with `gen_en`=0 loads `rd_data` into `rd_out` unchanged, including parity bits that are wrong. A parity error on `port_in` never changes `rd_out`.
- R7: While the R4 mailbox-read-with-generation condition holds, `perr_n` is 1 whatever `port_in` carries.
- R8: `rd_out` loads only on a rising clock edge where a read is set up (`cs_n`=0, `en`=1, `wr_rd`=0). At every other edge it keeps its value.
- R9: While `rst_n` is 0, `rd_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| odd_sel | input | 1 | Parity sense: 1 odd, 0 even |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Port transfer enable |
| wr_rd | input | 1 | 1 selects a write, 0 selects a read |
| mbx_sel | input | 1 | 1 selects the mailbox path, 0 the queue path |
| gen_en | input | 1 | Parity generation enable for reads |
| port_in | input | 36 | Word arriving on the port, checked passively |
| rd_data | input | 36 | Raw word to be read out |
| rd_out | output | 36 | Registered outgoing word, parity possibly regenerated |
| perr_n | output | 1 | Active-low parity error flag |

## Verification
The error flag is due in the same cycle as its stimulus. The bench drives inputs just after a falling edge and compares `perr_n` one time step later, before any rising edge. `rd_out` is due one rising edge after a read is set up. The reference model updates its expected word at that rising edge, and the bench compares it at the following falling edge, so each expected value lines up with exactly one register stage. Cycles with no read are compared the same way, which checks that the output holds its value.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

   typedef struct packed {
      logic cs_n;
      logic en;
      logic wr_rd;
      logic mbx_sel;
      logic gen_en;
   } bpar_ctrl_t;

   typedef enum logic [1:0] {
      RK_IDLE = 2'd0,
      RK_QUEUE = 2'd1,
      RK_MBOX = 2'd2
   } bpar_rd_kind_e;

endpackage

// File: rtl/bpar_ctrl_decode.sv
module bpar_ctrl_decode
   import bpar_pkg::*;
(
   input  bpar_ctrl_t    ctrl,
   output logic          rd_setup,
   output bpar_rd_kind_e rd_kind,
   output logic          mbx_gen,
   output logic          que_gen
);

   always_comb begin
      rd_setup = !ctrl.cs_n && ctrl.en && !ctrl.wr_rd;
      if (!rd_setup)
         rd_kind = RK_IDLE;
      else if (ctrl.mbx_sel)
         rd_kind = RK_MBOX;
      else
         rd_kind = RK_QUEUE;
      mbx_gen = (rd_kind == RK_MBOX) && ctrl.gen_en;
      que_gen = (rd_kind == RK_QUEUE) && ctrl.gen_en;
   end

endmodule

// File: rtl/bpar_lane_tree.sv
module bpar_lane_tree #(
   parameter int LANE_W = 9
) (
   input  logic [LANE_W-2:0] payload,
   input  logic              odd_sel,
   output logic              par_bit
);

   localparam int PAY_W = LANE_W - 1;

   logic [PAY_W-1:0] chain;

   // Explicit XOR chain: generated bit makes the lane match odd_sel.
   assign chain[0] = payload[0];
   for (genvar i = 1; i < PAY_W; i++) begin : g_chain
      assign chain[i] = chain[i-1] ^ payload[i];
   end

   assign par_bit = chain[PAY_W-1] ^ odd_sel;

endmodule

// File: rtl/bpar_out_stage.sv
module bpar_out_stage #(
   parameter int W       = 36,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (load)
            q <= d;
      end
   end else begin : g_pass
      assign q = d;
   end

endmodule

// File: rtl/byte_lane_parity.sv
module byte_lane_parity
   import bpar_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int LANE_W   = 9,
   parameter bit OUT_REG  = 1'b1,
   parameter bit QUE_GEN  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      odd_sel,
   input  logic                      cs_n,
   input  logic                      en,
   input  logic                      wr_rd,
   input  logic                      mbx_sel,
   input  logic                      gen_en,
   input  logic [LANES*LANE_W-1:0]   port_in,
   input  logic [LANES*LANE_W-1:0]   rd_data,
   output logic [LANES*LANE_W-1:0]   rd_out,
   output logic                      perr_n
);

   localparam int DATA_W = LANES * LANE_W;
   localparam int PAY_W  = LANE_W - 1;

   if (LANE_W < 2) begin : g_bad_lane
      $error("byte_lane_parity: LANE_W must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("byte_lane_parity: LANES must be at least 1");
   end

   bpar_ctrl_t    ctrl;
   logic          rd_setup;
   bpar_rd_kind_e rd_kind;
   logic          mbx_gen;
   logic          que_gen;

   assign ctrl = '{cs_n: cs_n, en: en, wr_rd: wr_rd, mbx_sel: mbx_sel, gen_en: gen_en};

   bpar_ctrl_decode u_dec (
      .ctrl     (ctrl),
      .rd_setup (rd_setup),
      .rd_kind  (rd_kind),
      .mbx_gen  (mbx_gen),
      .que_gen  (que_gen)
   );

   // Shared trees: check port_in normally, generate for mailbox reads.
   logic [DATA_W-1:0] sh_src;
   logic [LANES-1:0]  sh_par;
   logic [LANES-1:0]  lane_fail;
   logic [LANES-1:0]  q_par;

   assign sh_src = mbx_gen ? rd_data : port_in;

   for (genvar l = 0; l < LANES; l++) begin : g_shared
      bpar_lane_tree #(.LANE_W(LANE_W)) u_tree (
         .payload (sh_src[l*LANE_W +: PAY_W]),
         .odd_sel (odd_sel),
         .par_bit (sh_par[l])
      );
      assign lane_fail[l] = sh_par[l] ^ sh_src[l*LANE_W + PAY_W];
   end

   if (QUE_GEN) begin : g_que_trees
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         bpar_lane_tree #(.LANE_W(LANE_W)) u_tree (
            .payload (rd_data[l*LANE_W +: PAY_W]),
            .odd_sel (odd_sel),
            .par_bit (q_par[l])
         );
      end
   end else begin : g_no_que
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign q_par[l] = rd_data[l*LANE_W + PAY_W];
      end
   end

   assign perr_n = mbx_gen ? 1'b1 : ~(|lane_fail);

   // Outgoing word with lane top bits optionally replaced.
   logic [DATA_W-1:0] nxt_out;

   for (genvar l = 0; l < LANES; l++) begin : g_regen
      assign nxt_out[l*LANE_W +: PAY_W] = rd_data[l*LANE_W +: PAY_W];
      assign nxt_out[l*LANE_W + PAY_W]  = mbx_gen ? sh_par[l] :
                                          que_gen ? q_par[l]  :
                                          rd_data[l*LANE_W + PAY_W];
   end

   bpar_out_stage #(.W(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_setup),
      .d     (nxt_out),
      .q     (rd_out)
   );

endmodule

// File: rtl/bpar_checker.sv
module bpar_checker #(
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter bit OUT_REG = 1'b1,
   parameter bit QUE_GEN = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    odd_sel,
   input logic                    cs_n,
   input logic                    en,
   input logic                    wr_rd,
   input logic                    mbx_sel,
   input logic                    gen_en,
   input logic [LANES*LANE_W-1:0] port_in,
   input logic [LANES*LANE_W-1:0] rd_data,
   input logic [LANES*LANE_W-1:0] rd_out,
   input logic                    perr_n
);

   localparam int DATA_W = LANES * LANE_W;

   function automatic logic all_lanes_ok(input logic [DATA_W-1:0] v, input logic odd);
      logic ok;
      ok = 1'b1;
      for (int l = 0; l < LANES; l++) begin
         int ones;
         ones = 0;
         for (int b = 0; b < LANE_W; b++)
            ones += int'(v[l*LANE_W + b]);
         if ((ones % 2) != int'(odd))
            ok = 1'b0;
      end
      return ok;
   endfunction

   function automatic logic [DATA_W-1:0] pay_mask();
      logic [DATA_W-1:0] m;
      m = '1;
      for (int l = 0; l < LANES; l++)
         m[l*LANE_W + LANE_W - 1] = 1'b0;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] PMASK = pay_mask();

   logic rd_cond;
   logic mbx_cond;
   assign rd_cond  = !cs_n && en && !wr_rd;
   assign mbx_cond = rd_cond && mbx_sel && gen_en;

   p_check_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mbx_cond |-> (perr_n == all_lanes_ok(port_in, odd_sel)))
      else $error("p_check_r2");

   p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mbx_cond |-> perr_n)
      else $error("p_force_r7");

   if (OUT_REG) begin : g_seq
      p_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rd_cond |=> ((rd_out & PMASK) == ($past(rd_data) & PMASK)))
         else $error("p_payload_r4");

      p_mbx_par_r4: assert property (@(posedge clk) disable iff (!rst_n)
         mbx_cond |=> all_lanes_ok(rd_out, $past(odd_sel)))
         else $error("p_mbx_par_r4");

      p_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_cond && !gen_en) |=> (rd_out == $past(rd_data)))
         else $error("p_raw_r6");

      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_cond |=> $stable(rd_out))
         else $error("p_hold_r8");

      p_reset_r9: assert property (@(posedge clk)
         !rst_n |-> (rd_out == '0))
         else $error("p_reset_r9");

      if (QUE_GEN) begin : g_que
         p_que_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_cond && !mbx_sel && gen_en) |=> all_lanes_ok(rd_out, $past(odd_sel)))
            else $error("p_que_par_r5");
      end
   end

endmodule

bind byte_lane_parity bpar_checker #(
   .LANES(LANES), .LANE_W(LANE_W), .OUT_REG(OUT_REG), .QUE_GEN(QUE_GEN)
) u_bpar_chk (
   .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .cs_n(cs_n), .en(en),
   .wr_rd(wr_rd), .mbx_sel(mbx_sel), .gen_en(gen_en), .port_in(port_in),
   .rd_data(rd_data), .rd_out(rd_out), .perr_n(perr_n)
);

// File: tb/tb_byte_lane_parity.sv
module tb_byte_lane_parity;

   localparam int TCLK = 10;
   localparam int W = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic odd_sel = 1'b0;
   logic cs_n = 1'b1;
   logic en = 1'b0;
   logic wr_rd = 1'b1;
   logic mbx_sel = 1'b0;
   logic gen_en = 1'b0;
   logic [W-1:0] port_in = '0;
   logic [W-1:0] rd_data = '0;
   logic [W-1:0] rd_out;
   logic perr_n;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;
   logic [W-1:0] exp_out = '0;

   always #(TCLK/2) clk = ~clk;

   byte_lane_parity dut (
      .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .cs_n(cs_n), .en(en),
      .wr_rd(wr_rd), .mbx_sel(mbx_sel), .gen_en(gen_en), .port_in(port_in),
      .rd_data(rd_data), .rd_out(rd_out), .perr_n(perr_n)
   );

   function automatic int ones_in(input logic [W-1:0] v, input int lo, input int n);
      int c = 0;
      for (int i = 0; i < n; i++) c += int'(v[lo+i]);
      return c;
   endfunction

   // Word with correct parity per odd, lanes in bad_mask corrupted (R1 layout)
   function automatic logic [W-1:0] mk_word(input logic [31:0] pay, input logic odd,
                                            input logic [3:0] bad_mask);
      logic [W-1:0] v;
      for (int l = 0; l < 4; l++) begin
         int c;
         v[l*9 +: 8] = pay[l*8 +: 8];
         c = ones_in(v, l*9, 8);
         v[l*9+8] = ((c % 2) == 1) ? ~odd : odd;
         if (bad_mask[l]) v[l*9+8] = ~v[l*9+8];
      end
      return v;
   endfunction

   function automatic logic model_perr();
      if (!cs_n && en && !wr_rd && mbx_sel && gen_en) return 1'b1;
      for (int l = 0; l < 4; l++)
         if ((ones_in(port_in, l*9, 9) % 2) != int'(odd_sel)) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [W-1:0] model_out();
      logic [W-1:0] v;
      v = rd_data;
      if (gen_en)
         for (int l = 0; l < 4; l++)
            v[l*9+8] = ((ones_in(rd_data, l*9, 8) % 2) == 1) ? ~odd_sel : odd_sel;
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) exp_out = '0;
      else if (!cs_n && en && !wr_rd) exp_out = model_out();
   end

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: compare registered output, apply inputs, compare flag.
   task automatic step(input logic c_n, input logic e, input logic w, input logic m,
                       input logic g, input logic odd, input logic [W-1:0] pin,
                       input logic [W-1:0] rdd);
      @(negedge clk);
      check("R4/R5/R6/R8 rd_out", rd_out, exp_out);
      cs_n = c_n; en = e; wr_rd = w; mbx_sel = m; gen_en = g; odd_sel = odd;
      port_in = pin; rd_data = rdd;
      #1;
      check("R2/R3/R7 perr_n", {35'd0, perr_n}, {35'd0, model_perr()});
   endtask

   initial begin
      #(TCLK*200000);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] hold_v;
      // R9: reset holds rd_out at zero even with a read set up
      cs_n = 0; en = 1; wr_rd = 0; gen_en = 0; rd_data = 36'hFFFFFFFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset rd_out", rd_out, '0);
      // R3: flag works during reset, combinational
      port_in = mk_word(32'h12345678, 1'b0, 4'b0000); odd_sel = 0; #1;
      check("R3 perr_n clean", {35'd0, perr_n}, 36'd1);
      port_in = mk_word(32'h12345678, 1'b0, 4'b0100); #1;
      check("R3 perr_n bad lane", {35'd0, perr_n}, 36'd0);
      rst_n = 1;

      // R1/R2: single bad lane in each position, both senses
      for (int odd = 0; odd < 2; odd++)
         for (int l = 0; l < 4; l++) begin
            step(1, 0, 1, 0, 0, odd[0], mk_word(32'hA5C3_0F96, odd[0], 4'(1 << l)), '0);
            check("R1 lane flag", {35'd0, perr_n}, 36'd0);
            step(1, 0, 1, 0, 0, odd[0], mk_word(32'hA5C3_0F96, odd[0], 4'b0), '0);
            check("R2 clean flag", {35'd0, perr_n}, 36'd1);
         end
      // R2: even-clean word seen under odd sense fails
      step(1, 0, 1, 0, 0, 1'b1, mk_word(32'h0, 1'b0, 4'b0), '0);
      check("R2 wrong sense", {35'd0, perr_n}, 36'd0);

      // R7: mailbox read with generation forces flag high
      step(0, 1, 0, 1, 1, 1'b0, mk_word(32'hFFFF_FFFF, 1'b0, 4'hF), mk_word(32'h0102_0304, 1'b0, 4'hF));
      check("R7 forced", {35'd0, perr_n}, 36'd1);
      // R4: next edge regenerates parity
      step(1, 0, 1, 0, 0, 1'b0, '0, '0);
      check("R4 mbox regen", rd_out, mk_word(32'h0102_0304, 1'b0, 4'b0));
      // R5: queue read with generation, odd sense
      step(0, 1, 0, 0, 1, 1'b1, '0, mk_word(32'hDEAD_BEEF, 1'b1, 4'b1010));
      step(1, 0, 1, 0, 0, 1'b1, '0, '0);
      check("R5 queue regen", rd_out, mk_word(32'hDEAD_BEEF, 1'b1, 4'b0));
      // R6: no generation passes bad parity unchanged; bad port_in no effect
      hold_v = mk_word(32'hCAFE_0001, 1'b0, 4'b0011);
      step(0, 1, 0, 1, 0, 1'b0, mk_word(32'h5, 1'b0, 4'hF), hold_v);
      step(1, 0, 1, 0, 0, 1'b0, '0, '0);
      check("R6 raw pass", rd_out, hold_v);
      // R8: write, disabled, deselected: rd_out holds
      step(0, 1, 1, 0, 1, 1'b0, '0, 36'h123456789);
      step(0, 0, 0, 0, 1, 1'b0, '0, 36'h987654321);
      step(1, 1, 0, 1, 1, 1'b0, '0, 36'h111111111);
      step(1, 0, 1, 0, 0, 1'b0, '0, '0);
      check("R8 hold", rd_out, hold_v);

      // Random traffic compared against the model every cycle
      for (int i = 0; i < 400; i++) begin
         logic [3:0] bm;
         bm = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0;
         step($urandom_range(0, 3) == 0, $urandom_range(0, 4) != 0, 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom),
              mk_word($urandom, 1'($urandom), bm), {4'($urandom), 32'($urandom)});
      end
      step(1, 0, 1, 0, 0, 1'b0, '0, '0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule